// File: doc/BRIEF.md
# Watermarked Circular Sample Buffer

This block keeps a ring of samples inside a local memory, in a window given by a programmable base address and size. A producer pushes samples and a consumer pops them. Separate write and read pointers walk through the window and wrap back to its start. An occupancy counter tracks how many samples are held.

Two flags describe the level at a block granularity chosen by two 2-bit watermark fields. The "full" flag tells the producer that there is no longer room for a whole block. The "empty" flag tells the consumer that less than a whole block is waiting. Request outputs follow these flags. There is one interrupt line and one DMA request per direction, and each has its own enable. A request stays raised until its flag changes state. The owner sets the window and the watermarks while `run` is low, then raises `run`. Dropping `run` empties the ring and sends both pointers back to the base.

Top module: `wmbuf_top`

## Requirements
- R1: After reset the outputs are as follows: `level` is 0, `pop_data` is 0, both error bits are 0, and `irq`, `dma_wr_req` and `dma_rd_req` are low while `run` is low.
- R2: While `run` is high, a push with `level` < `cfg_size` stores `push_data`. A pop with `level` > 0 returns the oldest stored sample on `pop_data` one clock later. Samples come out in the order they went in.
- R3: Both pointers advance from address `cfg_base + cfg_size - 1` back to `cfg_base`. Ordering is kept across any number of wraps.
- R4: A watermark code w (0..3) selects a block of 2^w entries (1, 2, 4 or 8). `full_flag` is 1 exactly when `cfg_size - level` < 2^`cfg_full_wm`.
- R5: `empty_flag` is 1 exactly when `level` < 2^`cfg_empty_wm`.
- R6: `dma_wr_req` equals `run & wr_dma_en & !full_flag`. The write share of `irq` is `run & wr_irq_en & !full_flag`. It is raised in the same cycle `run` rises if the buffer is not full.
- R7: `dma_rd_req` equals `run & rd_dma_en & !empty_flag`. The read share of `irq` is `run & rd_irq_en & !empty_flag`. `irq` is the OR of the two shares.
- R8: A push when `level` equals `cfg_size` is dropped. The level does not grow, and `overflow_err` becomes 1 on the next clock. It stays 1 until `run` goes low.
- R9: A pop when `level` is 0 yields `pop_data` = 0 on the next clock. It sets `underflow_err`, which stays 1 until `run` goes low.
- R10: A push and a pop in the same cycle with 0 < `level` < `cfg_size` leave `level` unchanged. At `level` = `cfg_size` the pop is served and the push is dropped (R8). At `level` = 0 the push is stored and the pop underflows (R9).
- R11: One clock after `run` is low, `level` is 0, both error bits are 0, and pushes and pops have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run | input | 1 | Enables operation; low empties the ring |
| cfg_base | input | AW | First memory address of the window |
| cfg_size | input | AW+1 | Window length in entries (1..MEM_DEPTH-cfg_base) |
| cfg_full_wm | input | 2 | Producer block code, 2^w entries |
| cfg_empty_wm | input | 2 | Consumer block code, 2^w entries |
| wr_irq_en | input | 1 | Enables the write share of irq |
| wr_dma_en | input | 1 | Enables dma_wr_req |
| rd_irq_en | input | 1 | Enables the read share of irq |
| rd_dma_en | input | 1 | Enables dma_rd_req |
| push | input | 1 | Producer write strobe |
| push_data | input | DATA_W | Sample to write |
| pop | input | 1 | Consumer read strobe |
| pop_data | output | DATA_W | Sample read, valid the clock after pop |
| level | output | AW+1 | Entries held |
| full_flag | output | 1 | Less than one producer block free |
| empty_flag | output | 1 | Less than one consumer block held |
| irq | output | 1 | Combined interrupt request |
| dma_wr_req | output | 1 | DMA write request |
| dma_rd_req | output | 1 | DMA read request |
| overflow_err | output | 1 | Sticky dropped-push indicator |
| underflow_err | output | 1 | Sticky empty-pop indicator |

## Verification
A push and a pop can land in the same clock. The result then depends on where the level stands. The bench provokes this three ways: at a full ring, at an empty ring, and in a long stream that keeps one sample held while both pointers wrap several times. It judges each case against its own arithmetic model of the ring and checks `level`, `pop_data` and the error bits.

// File: rtl/wmbuf_pkg.sv
package wmbuf_pkg;

    typedef enum logic [1:0] {
        OP_IDLE = 2'b00,
        OP_PUSH = 2'b01,
        OP_POP  = 2'b10,
        OP_BOTH = 2'b11
    } op_e;

    function automatic logic [3:0] wm_block(input logic [1:0] wm);
        return 4'd1 << wm;
    endfunction

endpackage

// File: rtl/wmbuf_ptr.sv
module wmbuf_ptr #(
    parameter int AW = 5,
    parameter int CW = AW + 1
) (
    input  logic [AW-1:0] base,
    input  logic [CW-1:0] size,
    input  logic [AW-1:0] cur,
    output logic [AW-1:0] nxt
);
    logic [CW-1:0] last_addr;

    always_comb begin
        last_addr = CW'(base) + size - CW'(1);
        if ({1'b0, cur} == last_addr) begin
            nxt = base;
        end else begin
            nxt = cur + AW'(1);
        end
    end
endmodule

// File: rtl/wmbuf_req.sv
module wmbuf_req #(
    parameter int CW = 6
) (
    input  logic          run,
    input  logic [CW-1:0] count,
    input  logic [CW-1:0] size,
    input  logic [1:0]    full_wm,
    input  logic [1:0]    empty_wm,
    input  logic          wr_irq_en,
    input  logic          wr_dma_en,
    input  logic          rd_irq_en,
    input  logic          rd_dma_en,
    output logic          full,
    output logic          empty,
    output logic          irq,
    output logic          dma_wr,
    output logic          dma_rd
);
    import wmbuf_pkg::*;

    logic [CW-1:0] free_slots;
    logic          wr_want;
    logic          rd_want;

    always_comb begin
        free_slots = size - count;
        full       = free_slots < CW'(wm_block(full_wm));
        empty      = count < CW'(wm_block(empty_wm));
        wr_want    = run & ~full;
        rd_want    = run & ~empty;
        dma_wr     = wr_want & wr_dma_en;
        dma_rd     = rd_want & rd_dma_en;
        irq        = (wr_want & wr_irq_en) | (rd_want & rd_irq_en);
    end
endmodule

// File: rtl/wmbuf_top.sv
module wmbuf_top #(
    parameter  int DATA_W    = 16,
    parameter  int MEM_DEPTH = 32,
    localparam int AW        = $clog2(MEM_DEPTH),
    localparam int CW        = AW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [AW-1:0]     cfg_base,
    input  logic [CW-1:0]     cfg_size,
    input  logic [1:0]        cfg_full_wm,
    input  logic [1:0]        cfg_empty_wm,
    input  logic              wr_irq_en,
    input  logic              wr_dma_en,
    input  logic              rd_irq_en,
    input  logic              rd_dma_en,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [DATA_W-1:0] pop_data,
    output logic [CW-1:0]     level,
    output logic              full_flag,
    output logic              empty_flag,
    output logic              irq,
    output logic              dma_wr_req,
    output logic              dma_rd_req,
    output logic              overflow_err,
    output logic              underflow_err
);
    import wmbuf_pkg::*;

    localparam int NPTR = 2;
    localparam int WIDX = 0;
    localparam int RIDX = 1;

    typedef struct packed {
        logic [AW-1:0]     wptr;
        logic [AW-1:0]     rptr;
        logic [CW-1:0]     count;
        logic              ovf;
        logic              unf;
        logic [DATA_W-1:0] rdata;
    } state_t;

    state_t st_q, st_d;
    logic [DATA_W-1:0] mem_q [MEM_DEPTH];

    logic [NPTR-1:0][AW-1:0] cur_ptr;
    logic [NPTR-1:0][AW-1:0] nxt_ptr;
    logic has_room, has_data, do_push, do_pop;
    op_e  op;

    assign cur_ptr[WIDX] = st_q.wptr;
    assign cur_ptr[RIDX] = st_q.rptr;

    for (genvar g = 0; g < NPTR; g++) begin : g_ptr
        wmbuf_ptr #(.AW(AW), .CW(CW)) u_ptr (
            .base (cfg_base),
            .size (cfg_size),
            .cur  (cur_ptr[g]),
            .nxt  (nxt_ptr[g])
        );
    end

    wmbuf_req #(.CW(CW)) u_req (
        .run       (run),
        .count     (st_q.count),
        .size      (cfg_size),
        .full_wm   (cfg_full_wm),
        .empty_wm  (cfg_empty_wm),
        .wr_irq_en (wr_irq_en),
        .wr_dma_en (wr_dma_en),
        .rd_irq_en (rd_irq_en),
        .rd_dma_en (rd_dma_en),
        .full      (full_flag),
        .empty     (empty_flag),
        .irq       (irq),
        .dma_wr    (dma_wr_req),
        .dma_rd    (dma_rd_req)
    );

    always_comb begin
        has_room = st_q.count != cfg_size;
        has_data = st_q.count != '0;
        do_push  = run & push & has_room;
        do_pop   = run & pop & has_data;
        op       = op_e'({do_pop, do_push});

        st_d = st_q;
        if (!run) begin
            st_d.wptr  = cfg_base;
            st_d.rptr  = cfg_base;
            st_d.count = '0;
            st_d.ovf   = 1'b0;
            st_d.unf   = 1'b0;
        end else begin
            if (do_push) st_d.wptr = nxt_ptr[WIDX];
            if (do_pop)  st_d.rptr = nxt_ptr[RIDX];
            unique case (op)
                OP_PUSH: st_d.count = st_q.count + CW'(1);
                OP_POP:  st_d.count = st_q.count - CW'(1);
                default: st_d.count = st_q.count;
            endcase
            if (push && !has_room) st_d.ovf = 1'b1;
            if (pop && !has_data)  st_d.unf = 1'b1;
            if (pop) st_d.rdata = has_data ? mem_q[st_q.rptr] : '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem_q[st_q.wptr] <= push_data;
    end

    assign pop_data      = st_q.rdata;
    assign level         = st_q.count;
    assign overflow_err  = st_q.ovf;
    assign underflow_err = st_q.unf;
endmodule

// File: rtl/wmbuf_chk.sv
module wmbuf_chk #(
    parameter  int DATA_W    = 16,
    parameter  int MEM_DEPTH = 32,
    localparam int CW        = $clog2(MEM_DEPTH) + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              run,
    input logic [CW-1:0]     cfg_size,
    input logic              wr_dma_en,
    input logic              rd_dma_en,
    input logic              push,
    input logic              pop,
    input logic [DATA_W-1:0] pop_data,
    input logic [CW-1:0]     level,
    input logic              full_flag,
    input logic              empty_flag,
    input logic              dma_wr_req,
    input logic              dma_rd_req,
    input logic              overflow_err,
    input logic              underflow_err
);
    // R8
    level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> level <= cfg_size);

    // R8
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && push && !pop && level == cfg_size) |=> (overflow_err && $stable(level)));

    // R8
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && overflow_err) |=> overflow_err);

    // R9
    underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && pop && !push && level == '0) |=> (underflow_err && pop_data == '0 && level == '0));

    // R10
    both_ops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && push && pop && level != '0 && level != cfg_size) |=> $stable(level));

    // R6
    wr_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dma_wr_req |-> (run && wr_dma_en && !full_flag));

    // R7
    rd_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dma_rd_req |-> (run && rd_dma_en && !empty_flag));

    // R11
    stop_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (level == '0 && !overflow_err && !underflow_err));
endmodule

bind wmbuf_top wmbuf_chk #(.DATA_W(DATA_W), .MEM_DEPTH(MEM_DEPTH)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .run           (run),
    .cfg_size      (cfg_size),
    .wr_dma_en     (wr_dma_en),
    .rd_dma_en     (rd_dma_en),
    .push          (push),
    .pop           (pop),
    .pop_data      (pop_data),
    .level         (level),
    .full_flag     (full_flag),
    .empty_flag    (empty_flag),
    .dma_wr_req    (dma_wr_req),
    .dma_rd_req    (dma_rd_req),
    .overflow_err  (overflow_err),
    .underflow_err (underflow_err)
);

// File: tb/test_wmbuf_top.sv
module test_wmbuf_top;
    localparam int DW    = 16;
    localparam int DEPTH = 32;
    localparam int AW    = 5;
    localparam int CW    = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          run = 1'b0;
    logic [AW-1:0] cfg_base = '0;
    logic [CW-1:0] cfg_size = CW'(4);
    logic [1:0]    cfg_full_wm = '0;
    logic [1:0]    cfg_empty_wm = '0;
    logic          wr_irq_en = 1'b0, wr_dma_en = 1'b0, rd_irq_en = 1'b0, rd_dma_en = 1'b0;
    logic          push = 1'b0, pop = 1'b0;
    logic [DW-1:0] push_data = '0;
    logic [DW-1:0] pop_data;
    logic [CW-1:0] level;
    logic          full_flag, empty_flag, irq, dma_wr_req, dma_rd_req;
    logic          overflow_err, underflow_err;

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;
    int ser = 0;
    logic [DW-1:0] qm [64];
    int qh = 0, qt = 0, occ = 0;

    wmbuf_top #(.DATA_W(DW), .MEM_DEPTH(DEPTH)) i_wmbuf_top (
        .clk(clk), .rst_n(rst_n), .run(run), .cfg_base(cfg_base), .cfg_size(cfg_size),
        .cfg_full_wm(cfg_full_wm), .cfg_empty_wm(cfg_empty_wm),
        .wr_irq_en(wr_irq_en), .wr_dma_en(wr_dma_en), .rd_irq_en(rd_irq_en), .rd_dma_en(rd_dma_en),
        .push(push), .push_data(push_data), .pop(pop), .pop_data(pop_data), .level(level),
        .full_flag(full_flag), .empty_flag(empty_flag), .irq(irq),
        .dma_wr_req(dma_wr_req), .dma_rd_req(dma_rd_req),
        .overflow_err(overflow_err), .underflow_err(underflow_err)
    );

    always #10 clk = ~clk;

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(bit w, bit r);
        ser++;
        push      = w;
        push_data = DW'(ser * 37 + 11);
        pop       = r;
        @(negedge clk);
        push = 1'b0;
        pop  = 1'b0;
    endtask

    function automatic logic [DW-1:0] next_val();
        return DW'((ser + 1) * 37 + 11);
    endfunction

    task automatic model_push(logic [DW-1:0] v);
        qm[qt % 64] = v;
        qt++;
        occ++;
    endtask

    function automatic int model_pop();
        int v;
        v = int'(qm[qh % 64]);
        qh++;
        occ--;
        return v;
    endfunction

    task automatic check_flags();
        int  sz = int'(cfg_size);
        bit  ef = (sz - occ) < (1 << cfg_full_wm);
        bit  ee = occ < (1 << cfg_empty_wm);
        chk("R4 full_flag", full_flag, ef);
        chk("R5 empty_flag", empty_flag, ee);
        chk("R6 dma_wr_req", dma_wr_req, wr_dma_en & !ef);
        chk("R7 dma_rd_req", dma_rd_req, rd_dma_en & !ee);
        chk("R6 R7 irq", irq, (wr_irq_en & !ef) | (rd_irq_en & !ee));
        chk("R2 level", int'(level), occ);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            summary();
            $finish;
        end
    end

    initial begin
        int sizes [4] = '{1, 5, 8, 13};
        int cfg_idx = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 level", int'(level), 0);
        chk("R1 pop_data", int'(pop_data), 0);
        chk("R1 overflow_err", overflow_err, 0);
        chk("R1 underflow_err", underflow_err, 0);
        chk("R1 irq", irq, 0);
        chk("R1 dma_wr_req", dma_wr_req, 0);
        chk("R1 dma_rd_req", dma_rd_req, 0);

        for (int si = 0; si < 4; si++) begin
            for (int fw = 0; fw < 4; fw++) begin
                for (int ew = 0; ew < 4; ew++) begin
                    int sz = sizes[si];
                    int v;
                    cfg_size     = CW'(sz);
                    cfg_base     = AW'((sz * 5 + fw * 3 + ew) % (DEPTH - sz + 1));
                    cfg_full_wm  = 2'(fw);
                    cfg_empty_wm = 2'(ew);
                    wr_irq_en    = cfg_idx[0];
                    rd_irq_en    = cfg_idx[1];
                    wr_dma_en    = !cfg_idx[2];
                    rd_dma_en    = cfg_idx[0] ^ cfg_idx[3];
                    qh = 0; qt = 0; occ = 0;
                    run = 1'b1;
                    #1;
                    // R6: write request immediately after run rises
                    check_flags();
                    @(negedge clk);

                    // R2 R4 R5: fill one sample at a time
                    for (int i = 0; i < sz; i++) begin
                        model_push(next_val());
                        step(1, 0);
                        check_flags();
                    end
                    // R8: push at full is dropped
                    step(1, 0);
                    chk("R8 overflow_err", overflow_err, 1);
                    check_flags();
                    // R10: push and pop at full, pop served, push dropped
                    v = model_pop();
                    step(1, 1);
                    chk("R10 pop_data at full", int'(pop_data), v);
                    check_flags();
                    // R2 R3: drain with wrap
                    while (occ > 0) begin
                        v = model_pop();
                        step(0, 1);
                        chk("R3 pop order", int'(pop_data), v);
                        check_flags();
                    end
                    // R9: pop at empty
                    step(0, 1);
                    chk("R9 pop_data zero", int'(pop_data), 0);
                    chk("R9 underflow_err", underflow_err, 1);
                    check_flags();
                    // R10: push and pop at empty, push stored
                    model_push(next_val());
                    step(1, 1);
                    chk("R10 pop_data at empty", int'(pop_data), 0);
                    check_flags();
                    // R10 R3: streaming with one sample held, pointers wrap
                    if (sz >= 2) begin
                        for (int k = 0; k < 2 * sz + 3; k++) begin
                            model_push(next_val());
                            v = model_pop();
                            step(1, 1);
                            chk("R10 stream pop_data", int'(pop_data), v);
                            check_flags();
                        end
                    end
                    chk("R8 overflow sticky", overflow_err, 1);
                    // R11: stop clears and ignores access
                    run = 1'b0;
                    @(negedge clk);
                    chk("R11 level", int'(level), 0);
                    chk("R11 overflow_err", overflow_err, 0);
                    chk("R11 underflow_err", underflow_err, 0);
                    chk("R11 irq", irq, 0);
                    chk("R11 dma_wr_req", dma_wr_req, 0);
                    chk("R11 dma_rd_req", dma_rd_req, 0);
                    step(1, 0);
                    chk("R11 push ignored", int'(level), 0);
                    cfg_idx++;
                end
            end
        end
        done = 1;
        summary();
        $finish;
    end
endmodule